// File: doc/BRIEF.md
# E1 Frame Alignment Monitor

This block sits behind a frame hunter on the receive side of a 2.048 Mb/s E1 link. Once the hunter has located the 256-bit frame boundary, the monitor watches the serial stream one bit per clock. It checks three things. In alignment frames it checks the 7-bit alignment word in timeslot 0. In the other frames it checks the fixed-one bit of timeslot 0. In the first frame of each signalling multiframe it checks the 4-bit multiframe word in timeslot 16. It counts runs of consecutive bad words and decides when the link must be hunted again.

A resync can start in two ways. When a loss criterion is met and automatic resync is allowed, the block raises a one-cycle request towards the hunt engine. The request also comes from a rising edge on a manual control bit. Loss of sync stays high from the request until the hunt engine reports new alignment. While the link is out of sync, the run counters are held clear. Sticky flags record which criteria were met, and a separate control input clears them.

When CRC4 operation is enabled, a frame counter times the CRC4-level search. It runs while the link is frame-aligned but the CRC4 multiframe is not yet locked. When it reaches its limit, it raises a sticky timeout flag so that the search can be abandoned. The default limit is 3200 frames, which is 400 ms.

Top module: `e1am_monitor`

## Requirements
- R1: After reset, `los` is 1 and `resync_req`, `cas_resync_req`, all three sticky flags and `crc4_search_frames` are 0.
- R2: When a frame alignment word is received in error on three consecutive occasions, `frm_crit_flag` is set. If `auto_off` is 0, one `resync_req` pulse is also raised.
- R3: When `alt_crit` is 1, three consecutive errors in the non-alignment fixed bit also raise `resync_req`, and alignment-word errors still do. When `alt_crit` is 0, non-alignment errors never cause a resync.
- R4: With `auto_off` = 1, a met criterion still sets its flag, but it raises no `resync_req` or `cas_resync_req`, and `los` does not change.
- R5: A 0-to-1 transition of `man_rsync` raises exactly one `resync_req`. Holding it at 1 raises no further request. It must return to 0 and rise again before the next request.
- R6: When two consecutive signalling multiframe words are received in error, `cas_crit_flag` is set. If `auto_off` is 0, one `cas_resync_req` pulse is also raised.
- R7: Each run counter is cleared by a correctly received word of its own kind. Bad words separated by a good word do not add up.
- R8: `resync_req` sets `los` in the same cycle it appears. `los` clears only in the cycle after `align_found`. While `los` is 1, no word is evaluated.
- R9: While `crc4_en` = 1, `los` = 0 and `crc4_locked` = 0, `crc4_search_frames` counts frame starts and saturates at the limit. Reaching the limit sets `crc4_tmo_flag`. If any of those three conditions stops holding, the count clears on the next cycle.
- R10: All sticky flags hold until `flag_clr` is pulsed. If a set and a clear arrive in the same cycle, the flag stays set.
- R11: Bit positions count from 0 at `frm_sync`. The alignment word is 0011011 in positions 1 to 7 of alignment frames (`frm_fas` = 1 at `frm_sync`), and position 0 is ignored. In other frames, position 1 must be 1. The multiframe word is 0000 in positions 128 to 131 of frames with `mf_sync` = 1, and positions 132 to 135 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Received serial data bit |
| frm_sync | input | 1 | High on position 0 of each frame |
| frm_fas | input | 1 | Sampled with `frm_sync`: frame carries the alignment word |
| mf_sync | input | 1 | Sampled with `frm_sync`: frame carries the multiframe word |
| auto_off | input | 1 | 1 suppresses automatic resync |
| alt_crit | input | 1 | 1 adds the non-alignment bit criterion |
| man_rsync | input | 1 | Manual resync, acts on its rising edge |
| crc4_en | input | 1 | CRC4 operation enabled |
| crc4_locked | input | 1 | CRC4 multiframe alignment achieved |
| align_found | input | 1 | Hunt engine reports alignment regained |
| flag_clr | input | 1 | Clears the sticky flags |
| los | output | 1 | Loss of sync |
| resync_req | output | 1 | One-cycle frame resync request |
| cas_resync_req | output | 1 | One-cycle multiframe resync request |
| frm_crit_flag | output | 1 | Sticky: alignment-word criterion met |
| cas_crit_flag | output | 1 | Sticky: multiframe-word criterion met |
| crc4_tmo_flag | output | 1 | Sticky: CRC4 search time limit reached |
| crc4_search_frames | output | $clog2(TMO_FRAMES+1) | Frames spent in the CRC4-level search |

## Verification
The criteria are driven with error runs of length two, then a correct word, then more errors. This tells a true consecutive-run counter apart from a plain error total. The same non-alignment error runs are sent with each setting of the criterion select, which shows that the select adds a criterion without replacing the default one. Words that are corrupted only in the positions the monitor must ignore separate a correct bit-position decode from an off-by-one one. Error frames sent while out of sync, and a manual bit held high across many cycles, separate level-sensitive logic from edge-sensitive logic.

// File: rtl/e1am_pkg.sv
package e1am_pkg;

  // Frame geometry
  localparam int SLOT_BITS  = 8;
  localparam int SLOTS      = 32;
  localparam int FRAME_BITS = SLOTS * SLOT_BITS;
  localparam int POS_W      = $clog2(FRAME_BITS);

  // Timeslot-0 alignment word, positions 1..7, first received bit is MSB
  localparam int           FAS_W        = 7;
  localparam logic [6:0]   FAS_WORD     = 7'b0011011;
  localparam int           FAS_LAST_POS = FAS_W;

  // Fixed-one bit of non-alignment frames
  localparam int NFAS_POS = 1;

  // Signalling multiframe word in timeslot 16, positions 128..131
  localparam int         CAS_SLOT      = 16;
  localparam int         MFAS_W        = 4;
  localparam logic [3:0] MFAS_WORD     = 4'b0000;
  localparam int         MFAS_LAST_POS = CAS_SLOT * SLOT_BITS + MFAS_W - 1;

  // A word check event: chk marks the evaluation cycle, err its outcome
  typedef struct packed {
    logic chk;
    logic err;
  } word_evt_t;

endpackage

// File: rtl/e1am_phase.sv
module e1am_phase
  import e1am_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_sync,
  input  logic             frm_fas,
  input  logic             mf_sync,
  output logic [POS_W-1:0] pos,
  output logic             is_fas,
  output logic             is_mf,
  output logic             valid
);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             fas_q, fas_d;
  logic             mf_q,  mf_d;
  logic             vld_q, vld_d;

  always_comb begin
    if (frm_sync) begin
      pos_d = '0;
      fas_d = frm_fas;
      mf_d  = mf_sync;
      vld_d = 1'b1;
    end else begin
      pos_d = (pos_q == POS_W'(FRAME_BITS - 1)) ? '0 : pos_q + 1'b1;
      fas_d = fas_q;
      mf_d  = mf_q;
      vld_d = vld_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      fas_q <= 1'b0;
      mf_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      fas_q <= fas_d;
      mf_q  <= mf_d;
      vld_q <= vld_d;
    end
  end

  // Position and frame type of the bit on rx_bit this cycle
  assign pos    = pos_d;
  assign is_fas = fas_d;
  assign is_mf  = mf_d;
  assign valid  = vld_d;

endmodule

// File: rtl/e1am_word_chk.sv
module e1am_word_chk
  import e1am_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic [POS_W-1:0] pos,
  input  logic             is_fas,
  input  logic             is_mf,
  input  logic             valid,
  output word_evt_t        fas_ev,
  output word_evt_t        nfas_ev,
  output word_evt_t        mfas_ev
);

  localparam int SH_W = FAS_W - 1;

  logic [SH_W-1:0]   sh_q, sh_d;
  logic [FAS_W-1:0]  fas_word;
  logic [MFAS_W-1:0] mfas_word;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], rx_bit};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign fas_word  = {sh_q, rx_bit};
  assign mfas_word = {sh_q[MFAS_W-2:0], rx_bit};

  always_comb begin
    fas_ev.chk  = valid & is_fas & (pos == POS_W'(FAS_LAST_POS));
    fas_ev.err  = (fas_word != FAS_WORD);
    nfas_ev.chk = valid & ~is_fas & (pos == POS_W'(NFAS_POS));
    nfas_ev.err = ~rx_bit;
    mfas_ev.chk = valid & is_mf & (pos == POS_W'(MFAS_LAST_POS));
    mfas_ev.err = (mfas_word != MFAS_WORD);
  end

endmodule

// File: rtl/e1am_err_run.sv
module e1am_err_run
  import e1am_pkg::*;
#(
  parameter int THRESH = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hold,
  input  word_evt_t ev,
  output logic      met
);

  localparam int CW = $clog2(THRESH + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign met    = ev.chk & ev.err & (cnt_q == CW'(THRESH - 1));
  assign cnt_en = hold | ev.chk;

  always_comb begin
    if (hold || !ev.err || met) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/e1am_crc_timer.sv
module e1am_crc_timer #(
  parameter int LIMIT = 3200,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          tick,
  output logic [CW-1:0] cnt,
  output logic          expire
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_cap;

  assign at_cap = (cnt_q == CW'(LIMIT));
  assign expire = active & tick & (cnt_q == CW'(LIMIT - 1));

  always_comb begin
    if (!active) begin
      cnt_d = '0;
    end else if (tick && !at_cap) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/e1am_monitor.sv
module e1am_monitor
  import e1am_pkg::*;
#(
  parameter int TMO_FRAMES = 3200,
  parameter int FAS_RUN    = 3,
  parameter int NFAS_RUN   = 3,
  parameter int CAS_RUN    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic frm_sync,
  input  logic frm_fas,
  input  logic mf_sync,
  input  logic auto_off,
  input  logic alt_crit,
  input  logic man_rsync,
  input  logic crc4_en,
  input  logic crc4_locked,
  input  logic align_found,
  input  logic flag_clr,
  output logic los,
  output logic resync_req,
  output logic cas_resync_req,
  output logic frm_crit_flag,
  output logic cas_crit_flag,
  output logic crc4_tmo_flag,
  output logic [$clog2(TMO_FRAMES+1)-1:0] crc4_search_frames
);

  logic [POS_W-1:0] pos;
  logic             is_fas, is_mf, valid;
  word_evt_t        fas_ev, nfas_ev, mfas_ev;
  word_evt_t        fas_g, nfas_g, mfas_g;
  logic             fas_met, nfas_met, cas_met;
  logic             tmo_hit, crc_active;

  logic los_q, los_d;
  logic req_q, req_d;
  logic creq_q, creq_d;
  logic man_q;
  logic man_rise;
  logic ff_q, ff_d, cf_q, cf_d, tf_q, tf_d;

  e1am_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .frm_sync (frm_sync),
    .frm_fas  (frm_fas),
    .mf_sync  (mf_sync),
    .pos      (pos),
    .is_fas   (is_fas),
    .is_mf    (is_mf),
    .valid    (valid)
  );

  e1am_word_chk u_words (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_bit  (rx_bit),
    .pos     (pos),
    .is_fas  (is_fas),
    .is_mf   (is_mf),
    .valid   (valid),
    .fas_ev  (fas_ev),
    .nfas_ev (nfas_ev),
    .mfas_ev (mfas_ev)
  );

  // No word is judged while the hunt engine owns the link
  always_comb begin
    fas_g  = '{chk: fas_ev.chk  & ~los_q, err: fas_ev.err};
    nfas_g = '{chk: nfas_ev.chk & ~los_q, err: nfas_ev.err};
    mfas_g = '{chk: mfas_ev.chk & ~los_q, err: mfas_ev.err};
  end

  e1am_err_run #(.THRESH(FAS_RUN)) u_run_fas (
    .clk (clk), .rst_n (rst_n), .hold (los_q), .ev (fas_g), .met (fas_met)
  );

  e1am_err_run #(.THRESH(NFAS_RUN)) u_run_nfas (
    .clk (clk), .rst_n (rst_n), .hold (los_q), .ev (nfas_g), .met (nfas_met)
  );

  e1am_err_run #(.THRESH(CAS_RUN)) u_run_cas (
    .clk (clk), .rst_n (rst_n), .hold (los_q), .ev (mfas_g), .met (cas_met)
  );

  assign crc_active = crc4_en & ~los_q & ~crc4_locked;

  e1am_crc_timer #(.LIMIT(TMO_FRAMES)) u_crc_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (crc_active),
    .tick   (frm_sync),
    .cnt    (crc4_search_frames),
    .expire (tmo_hit)
  );

  // Resync decision and loss-of-sync state
  always_comb begin
    man_rise = man_rsync & ~man_q;
    req_d    = (~auto_off & (fas_met | (alt_crit & nfas_met))) | man_rise;
    creq_d   = ~auto_off & cas_met;
    if (req_d) begin
      los_d = 1'b1;
    end else if (align_found) begin
      los_d = 1'b0;
    end else begin
      los_d = los_q;
    end
    ff_d = fas_met | (ff_q & ~flag_clr);
    cf_d = cas_met | (cf_q & ~flag_clr);
    tf_d = tmo_hit | (tf_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      los_q  <= 1'b1;
      req_q  <= 1'b0;
      creq_q <= 1'b0;
      man_q  <= 1'b0;
      ff_q   <= 1'b0;
      cf_q   <= 1'b0;
      tf_q   <= 1'b0;
    end else begin
      los_q  <= los_d;
      req_q  <= req_d;
      creq_q <= creq_d;
      man_q  <= man_rsync;
      ff_q   <= ff_d;
      cf_q   <= cf_d;
      tf_q   <= tf_d;
    end
  end

  assign los            = los_q;
  assign resync_req     = req_q;
  assign cas_resync_req = creq_q;
  assign frm_crit_flag  = ff_q;
  assign cas_crit_flag  = cf_q;
  assign crc4_tmo_flag  = tf_q;

endmodule

// File: rtl/e1am_monitor_chk.sv
module e1am_monitor_chk #(
  parameter int TMO = 3200
) (
  input logic clk,
  input logic rst_n,
  input logic auto_off,
  input logic man_rsync,
  input logic crc4_en,
  input logic align_found,
  input logic los,
  input logic resync_req,
  input logic cas_resync_req,
  input logic frm_crit_flag,
  input logic crc4_tmo_flag,
  input logic [$clog2(TMO+1)-1:0] crc4_search_frames
);

  logic man_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_seen <= 1'b0;
    end else begin
      man_seen <= man_rsync;
    end
  end

  // R8: a request always comes with loss of sync
  assert_req_sets_los_R8: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |-> los);

  // R8: loss of sync ends only after the hunt engine reports alignment
  assert_los_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(los) |-> $past(align_found));

  // R4 / R5: with auto resync off, only a manual rising edge may request
  assert_auto_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resync_req |-> ($past(!auto_off) || ($past(man_rsync) && !$past(man_seen))));

  // R6: multiframe request also obeys the auto resync gate
  assert_cas_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cas_resync_req |-> $past(!auto_off));

  // R2 / R8: the alignment criterion can only be met while in sync
  assert_flag_in_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_crit_flag) |-> $past(!los));

  // R9: the search counter saturates at its limit
  assert_tmo_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    crc4_search_frames <= ($clog2(TMO+1))'(TMO));

  // R9: leaving CRC4 mode clears the counter
  assert_tmo_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !crc4_en |=> crc4_search_frames == '0);

  // R9: timeout flag rises only with the counter at its limit
  assert_tmo_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc4_tmo_flag) |-> crc4_search_frames == ($clog2(TMO+1))'(TMO));

endmodule

bind e1am_monitor e1am_monitor_chk #(.TMO(TMO_FRAMES)) u_chk (
  .clk                (clk),
  .rst_n              (rst_n),
  .auto_off           (auto_off),
  .man_rsync          (man_rsync),
  .crc4_en            (crc4_en),
  .align_found        (align_found),
  .los                (los),
  .resync_req         (resync_req),
  .cas_resync_req     (cas_resync_req),
  .frm_crit_flag      (frm_crit_flag),
  .crc4_tmo_flag      (crc4_tmo_flag),
  .crc4_search_frames (crc4_search_frames)
);

// File: tb/test_e1am_monitor.sv
`timescale 1ns/1ps
module test_e1am_monitor;

  localparam int TMO = 6;
  localparam int CW  = $clog2(TMO + 1);

  logic clk, rst_n;
  logic rx_bit, frm_sync, frm_fas, mf_sync;
  logic auto_off, alt_crit, man_rsync, crc4_en, crc4_locked, align_found, flag_clr;
  logic los, resync_req, cas_resync_req, frm_crit_flag, cas_crit_flag, crc4_tmo_flag;
  logic [CW-1:0] crc4_search_frames;

  int total = 0;
  int bad   = 0;
  int rs_seen  = 0;
  int cas_seen = 0;
  bit done = 0;

  e1am_monitor #(.TMO_FRAMES(TMO)) i_e1am_monitor (
    .clk (clk), .rst_n (rst_n), .rx_bit (rx_bit), .frm_sync (frm_sync),
    .frm_fas (frm_fas), .mf_sync (mf_sync), .auto_off (auto_off),
    .alt_crit (alt_crit), .man_rsync (man_rsync), .crc4_en (crc4_en),
    .crc4_locked (crc4_locked), .align_found (align_found), .flag_clr (flag_clr),
    .los (los), .resync_req (resync_req), .cas_resync_req (cas_resync_req),
    .frm_crit_flag (frm_crit_flag), .cas_crit_flag (cas_crit_flag),
    .crc4_tmo_flag (crc4_tmo_flag), .crc4_search_frames (crc4_search_frames)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (resync_req)     rs_seen  <= rs_seen + 1;
    if (cas_resync_req) cas_seen <= cas_seen + 1;
  end

  // Table: {af, alt, fas_err, nfas_err, exp_los, exp_flag, exp_requests[3:0]}
  localparam logic [9:0] TBL [19] = '{
    10'b1_0_0_0_0_0_0000,  // regain alignment
    10'b0_0_1_0_0_0_0000,
    10'b0_0_1_0_0_0_0000,
    10'b0_0_0_0_0_0_0000,  // good word clears run (R7)
    10'b0_0_1_0_0_0_0000,
    10'b0_0_1_0_0_0_0000,
    10'b0_0_1_0_1_1_0001,  // third in a row (R2)
    10'b1_0_0_1_0_1_0001,
    10'b0_0_0_1_0_1_0001,
    10'b0_0_0_1_0_1_0001,  // default criterion ignores these (R3)
    10'b0_1_0_1_0_1_0001,
    10'b0_1_0_1_0_1_0001,
    10'b0_1_0_0_0_1_0001,  // cleared (R7)
    10'b0_1_0_1_0_1_0001,
    10'b0_1_0_1_0_1_0001,
    10'b0_1_0_1_1_1_0010,  // alternate criterion fires (R3)
    10'b1_1_1_0_0_1_0010,
    10'b0_1_1_0_0_1_0010,
    10'b0_1_1_0_1_1_0011   // alignment word still counts (R3)
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic send_frame(input logic af, input logic fas, input logic mf,
                            input logic [7:0] ts0, input logic [7:0] ts16);
    for (int p = 0; p < 256; p++) begin
      frm_sync    = (p == 0);
      frm_fas     = fas;
      mf_sync     = mf;
      align_found = af && (p == 0);
      if (p < 8)                  rx_bit = ts0[7-p];
      else if (p >= 128 && p < 136) rx_bit = ts16[135-p];
      else                        rx_bit = 1'b1;
      @(posedge clk);
      #1;
    end
    frm_sync    = 1'b0;
    align_found = 1'b0;
  endtask

  task automatic send_pair(input logic af, input logic fe, input logic ne,
                           input logic mf, input logic [7:0] ts16);
    send_frame(af, 1'b1, mf, fe ? 8'h80 : 8'h9B, ts16);
    send_frame(1'b0, 1'b0, 1'b0, ne ? 8'hBF : 8'hFF, 8'hFF);
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    tick(1);
    flag_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int rs0, cs0;
    rst_n = 1'b0; rx_bit = 1'b1; frm_sync = 1'b0; frm_fas = 1'b0; mf_sync = 1'b0;
    auto_off = 1'b0; alt_crit = 1'b0; man_rsync = 1'b0; crc4_en = 1'b0;
    crc4_locked = 1'b0; align_found = 1'b0; flag_clr = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 reset state
    check("R1 los", los, 1);
    check("R1 flags", {frm_crit_flag, cas_crit_flag, crc4_tmo_flag}, 0);
    check("R1 requests", rs_seen + cas_seen, 0);
    check("R1 crc4 count", crc4_search_frames, 0);

    // Table walk: R2 R3 R7 R8
    for (int k = 0; k < 19; k++) begin
      alt_crit = TBL[k][8];
      send_pair(TBL[k][9], TBL[k][7], TBL[k][6], 1'b0, 8'hFF);
      check($sformatf("R2/R3/R7 los row %0d", k), los, TBL[k][5]);
      check($sformatf("R2 flag row %0d", k), frm_crit_flag, TBL[k][4]);
      check($sformatf("R3 requests row %0d", k), rs_seen, int'(TBL[k][3:0]));
    end

    // R10 sticky flag clear
    clear_flags();
    check("R10 flag cleared", frm_crit_flag, 0);

    // R8 no evaluation while out of sync
    alt_crit = 1'b0;
    rs0 = rs_seen;
    for (int i = 0; i < 3; i++) send_pair(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF);
    check("R8 ignored while los", rs_seen, rs0);
    check("R8 flag while los", frm_crit_flag, 0);
    send_pair(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF);
    send_pair(1'b0, 1'b1, 1'b0, 1'b0, 8'hFF);
    check("R8 los cleared by align_found", los, 0);
    check("R8 run started fresh", rs_seen, rs0);
    send_pair(1'b0, 1'b1, 1'b0, 1'b0, 8'hFF);
    check("R8 third error fires", rs_seen, rs0 + 1);

    // R11 position 0 of the alignment frame is ignored
    clear_flags();
    send_pair(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    rs0 = rs_seen;
    for (int i = 0; i < 3; i++) begin
      send_frame(1'b0, 1'b1, 1'b0, 8'h1B, 8'hFF);
      send_frame(1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF);
    end
    check("R11 bit0 ignored requests", rs_seen, rs0);
    check("R11 bit0 ignored flag", frm_crit_flag, 0);

    // R4 auto resync disabled
    auto_off = 1'b1;
    for (int i = 0; i < 3; i++) send_pair(1'b0, 1'b1, 1'b0, 1'b0, 8'hFF);
    check("R4 flag set", frm_crit_flag, 1);
    check("R4 no request", rs_seen, rs0);
    check("R4 los stays low", los, 0);
    auto_off = 1'b0;

    // R6 / R7 / R11 multiframe word
    clear_flags();
    cs0 = cas_seen;
    send_pair(1'b0, 1'b0, 1'b0, 1'b1, 8'hFB);
    send_pair(1'b0, 1'b0, 1'b0, 1'b1, 8'h0F);
    send_pair(1'b0, 1'b0, 1'b0, 1'b1, 8'hFB);
    check("R7 cas run cleared", cas_crit_flag, 0);
    check("R11 cas tail ignored", cas_seen, cs0);
    send_pair(1'b0, 1'b0, 1'b0, 1'b1, 8'h8B);
    check("R6 cas flag", cas_crit_flag, 1);
    check("R6 cas request", cas_seen, cs0 + 1);
    check("R6 frame sync kept", los, 0);
    clear_flags();
    auto_off = 1'b1;
    send_pair(1'b0, 1'b0, 1'b0, 1'b1, 8'h4B);
    send_pair(1'b0, 1'b0, 1'b0, 1'b1, 8'h2B);
    check("R4 cas flag gated run", cas_crit_flag, 1);
    check("R4 cas no request", cas_seen, cs0 + 1);
    auto_off = 1'b0;

    // R5 manual resync edge
    rs0 = rs_seen;
    man_rsync = 1'b1;
    tick(20);
    check("R5 one request on rise", rs_seen, rs0 + 1);
    check("R5 los set", los, 1);
    man_rsync = 1'b0;
    tick(3);
    check("R5 no request on fall", rs_seen, rs0 + 1);
    man_rsync = 1'b1;
    tick(3);
    check("R5 second rise", rs_seen, rs0 + 2);
    man_rsync = 1'b0;

    // R9 CRC4 search timer
    clear_flags();
    crc4_en = 1'b1;
    send_pair(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    send_pair(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    check("R9 counting frames", crc4_search_frames, 3);
    check("R9 no early timeout", crc4_tmo_flag, 0);
    crc4_locked = 1'b1;
    tick(1);
    check("R9 lock clears count", crc4_search_frames, 0);
    crc4_locked = 1'b0;
    for (int i = 0; i < 3; i++) send_pair(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    check("R9 reached limit", crc4_search_frames, TMO);
    check("R9 timeout flag", crc4_tmo_flag, 1);
    send_pair(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF);
    check("R9 saturates", crc4_search_frames, TMO);
    crc4_en = 1'b0;
    tick(1);
    check("R9 disable clears", crc4_search_frames, 0);
    check("R10 timeout flag held", crc4_tmo_flag, 1);
    clear_flags();
    check("R10 timeout flag cleared", crc4_tmo_flag, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule